// File: doc/BRIEF.md
# Center-Aligned PWM Timebase with Period-Boundary Reload

This block is the timebase of a center-aligned PWM channel. A counter climbs from zero to a programmed period value, turns, and descends back to zero. A direction flag travels with the count. The block decodes the count into single-cycle event pulses and a PWM level:

- a compare match while climbing;
- a compare match while descending;
- the turning point (peak);
- the zero point.

Software writes the period and compare values through a small write port. Address 0 is the period and address 1 is the compare value. Address 2 is control: bit 0 enables counting and bit 1 selects immediate loading.

The working copies that drive the counter and decoder are shadow registers. In the default boundary-load mode, the shadows refresh from the written registers only on the cycle in which the enabled counter sits at zero. A write in mid-period therefore changes nothing until the following period. The period and compare shadows refresh independently of each other. In immediate mode, each shadow follows its register one cycle after a write.

The zero cycle is shared between two periods. When zero is reached by descending, it carries the down direction and ends the current period. The next cycle is 1 with the up direction. After reset, and whenever the period is 0, zero carries the up direction.

Top module: `updown_pwm_timebase`

## Requirements
- R1: After reset the count is 0, the direction flag is 0 (up), both shadows and both written values are 0, counting is disabled, and all event outputs and the PWM level are 0.
- R2: While enabled with a shadow period P>0, the count runs 0,1,…,P with direction 0, then P−1,…,1,0 with direction 1. It then continues at 1 with direction 0.
- R3: The up-compare pulse fires in a cycle where the direction is 0 and the count equals the compare shadow. It never fires when the compare shadow equals the period shadow.
- R4: The down-compare pulse fires in a cycle where the direction is 1 and the count equals the compare shadow. This includes a compare of 0 at the closing zero of a period.
- R5: The zero pulse fires in every enabled cycle with count 0. The peak pulse fires in the enabled cycle where the count equals a nonzero period shadow with direction 0.
- R6: With control bit 1 at 0, the shadows copy the written values only in an enabled cycle with count 0. A mid-period write leaves the running period's turning point and PWM level unchanged.
- R7: The period and compare shadows reload independently. A period after a compare-only write keeps the old period and uses the new compare.
- R8: With control bit 1 at 1, a written value reaches its shadow on the clock edge after the write edge, without waiting for zero.
- R9: While control bit 0 is 0, the count and direction hold and no event pulse fires.
- R10: A period shadow of 0 keeps the count at 0 with direction 0, and a zero pulse fires in each enabled cycle.
- R11: The PWM level is 1 exactly when the count is below the compare shadow. A compare above the period keeps it high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 period, 1 compare, 2 control |
| wr_data | input | CNT_W | Write data; control uses bit 0 enable, bit 1 immediate load |
| cnt_o | output | CNT_W | Current count |
| dir_down_o | output | 1 | 1 while descending |
| evt_cmp_up | output | 1 | Compare match while ascending |
| evt_cmp_dn | output | 1 | Compare match while descending |
| evt_zero | output | 1 | Count at zero |
| evt_peak | output | 1 | Count at the period turning point |
| pwm_o | output | 1 | Center-aligned PWM level |

## Verification
The hardest situation to reach from the ports is a write that lands in the middle of a running period. The bench has to show that this write does not move the current turning point, yet does move the next one. The stimulus counts cycles from a known zero so that the period and compare writes fall at a chosen count. It then confirms that the peak pulse appears at the old period value. Next it measures the maximum count and the number of PWM-high cycles over the whole following period. A compare-only write in a later period separates the two shadows. A late compare write under each load mode shows the one-cycle latency of immediate loading against the period-boundary hold.

// File: rtl/updown_pwm_pkg.sv
package updown_pwm_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PERIOD  = 2'd0,
    REG_COMPARE = 2'd1,
    REG_CONTROL = 2'd2
  } reg_addr_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_IMM_BIT = 1;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import updown_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              period_end,
  output logic [CNT_W-1:0]  prd_act,
  output logic [CNT_W-1:0]  cmp_act,
  output logic              run_en,
  output logic              imm_load,
  output logic              load_now
);
  logic [CNT_W-1:0] prd_reg, cmp_reg;
  logic             unused_ctrl_bits;

  assign unused_ctrl_bits = ^wr_data[CNT_W-1:2];
  assign load_now = imm_load | period_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_reg  <= '0;
      cmp_reg  <= '0;
      run_en   <= 1'b0;
      imm_load <= 1'b0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        REG_PERIOD:  prd_reg <= wr_data;
        REG_COMPARE: cmp_reg <= wr_data;
        REG_CONTROL: begin
          run_en   <= wr_data[CTRL_EN_BIT];
          imm_load <= wr_data[CTRL_IMM_BIT];
        end
        default: ;
      endcase
    end
  end

  // Each shadow copies its own register; both share the load moment.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_act <= '0;
      cmp_act <= '0;
    end else if (load_now) begin
      prd_act <= prd_reg;
      cmp_act <= cmp_reg;
    end
  end
endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] prd_act,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_down,
  output logic             at_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Returns {next_dir_down, next_count}.
  function automatic logic [CNT_W:0] step_count(
    input logic [CNT_W-1:0] c,
    input logic             dn,
    input logic [CNT_W-1:0] p
  );
    if (p == '0)      return {1'b0, {CNT_W{1'b0}}};
    if (!dn) begin
      if (c >= p)     return {1'b1, c - ONE};
      else            return {1'b0, c + ONE};
    end
    if (c == '0)      return {1'b0, ONE};
    return {1'b1, c - ONE};
  endfunction

  logic [CNT_W:0] nxt;
  assign nxt     = step_count(cnt, dir_down, prd_act);
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_down <= 1'b0;
    end else if (run_en) begin
      cnt      <= nxt[CNT_W-1:0];
      dir_down <= nxt[CNT_W];
    end
  end
endmodule

// File: rtl/pwm_event_decode.sv
module pwm_event_decode #(
  parameter int CNT_W = 16
) (
  input  logic             run_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_down,
  input  logic [CNT_W-1:0] prd_act,
  input  logic [CNT_W-1:0] cmp_act,
  output logic             evt_cmp_up,
  output logic             evt_cmp_dn,
  output logic             evt_zero,
  output logic             evt_peak,
  output logic             pwm_level
);
  function automatic logic hit_up(input logic [CNT_W-1:0] c, input logic dn,
                                  input logic [CNT_W-1:0] m, input logic [CNT_W-1:0] p);
    return !dn && (c == m) && (m != p);
  endfunction

  function automatic logic hit_dn(input logic [CNT_W-1:0] c, input logic dn,
                                  input logic [CNT_W-1:0] m);
    return dn && (c == m);
  endfunction

  always_comb begin
    evt_cmp_up = run_en && hit_up(cnt, dir_down, cmp_act, prd_act);
    evt_cmp_dn = run_en && hit_dn(cnt, dir_down, cmp_act);
    evt_zero   = run_en && (cnt == '0);
    evt_peak   = run_en && !dir_down && (prd_act != '0) && (cnt == prd_act);
    pwm_level  = (cnt < cmp_act);
  end
endmodule

// File: rtl/updown_pwm_timebase.sv
module updown_pwm_timebase
  import updown_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dir_down_o,
  output logic              evt_cmp_up,
  output logic              evt_cmp_dn,
  output logic              evt_zero,
  output logic              evt_peak,
  output logic              pwm_o
);
  logic [CNT_W-1:0] prd_act, cmp_act;
  logic             run_en, imm_load, load_now, at_zero, period_end;

  assign period_end = run_en & at_zero;

  pwm_shadow_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period_end(period_end), .prd_act(prd_act),
    .cmp_act(cmp_act), .run_en(run_en), .imm_load(imm_load),
    .load_now(load_now)
  );

  pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .prd_act(prd_act),
    .cnt(cnt_o), .dir_down(dir_down_o), .at_zero(at_zero)
  );

  pwm_event_decode #(.CNT_W(CNT_W)) u_dec (
    .run_en(run_en), .cnt(cnt_o), .dir_down(dir_down_o),
    .prd_act(prd_act), .cmp_act(cmp_act), .evt_cmp_up(evt_cmp_up),
    .evt_cmp_dn(evt_cmp_dn), .evt_zero(evt_zero), .evt_peak(evt_peak),
    .pwm_level(pwm_o)
  );
endmodule

// File: rtl/updown_pwm_timebase_chk.sv
module updown_pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             imm_load,
  input logic             period_end,
  input logic [CNT_W-1:0] prd_act,
  input logic [CNT_W-1:0] cmp_act,
  input logic [CNT_W-1:0] cnt_o,
  input logic             dir_down_o,
  input logic             evt_cmp_up,
  input logic             evt_cmp_dn,
  input logic             evt_zero,
  input logic             evt_peak
);
  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(cnt_o) && $stable(dir_down_o));

  // R9
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !(evt_cmp_up || evt_cmp_dn || evt_zero || evt_peak));

  // R3
  no_up_at_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == prd_act) |-> !evt_cmp_up);

  // R2
  count_up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !dir_down_o && cnt_o < prd_act) |=> (cnt_o == $past(cnt_o) + 1'b1));

  // R10
  flat_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && prd_act == '0) |=> (cnt_o == '0) && !dir_down_o);

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_load && !period_end) |=> $stable(prd_act) && $stable(cmp_act));

  // R5
  peak_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_peak |-> !dir_down_o && !evt_zero);
endmodule

bind updown_pwm_timebase updown_pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .imm_load(imm_load),
  .period_end(period_end), .prd_act(prd_act), .cmp_act(cmp_act),
  .cnt_o(cnt_o), .dir_down_o(dir_down_o), .evt_cmp_up(evt_cmp_up),
  .evt_cmp_dn(evt_cmp_dn), .evt_zero(evt_zero), .evt_peak(evt_peak)
);

// File: tb/updown_pwm_timebase_bench.sv
module updown_pwm_timebase_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NVEC = 6;
  // {period, compare, up events, down events, peak events, pwm-high cycles}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'd4, 16'd2, 4'd1, 4'd1, 4'd1, 4'd4},
    {16'd4, 16'd4, 4'd0, 4'd0, 4'd1, 4'd8},
    {16'd7, 16'd5, 4'd1, 4'd1, 4'd1, 4'd10},
    {16'd5, 16'd0, 4'd1, 4'd1, 4'd1, 4'd0},
    {16'd3, 16'd9, 4'd0, 4'd0, 4'd1, 4'd7},
    {16'd1, 16'd1, 4'd0, 4'd0, 4'd1, 4'd2}
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt_o;
  logic dir_down_o, evt_cmp_up, evt_cmp_dn, evt_zero, evt_peak, pwm_o;
  int checks = 0, failures = 0, cycles = 0;
  int mx, npwm, npk;

  updown_pwm_timebase #(.CNT_W(W)) u_updown_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .dir_down_o(dir_down_o),
    .evt_cmp_up(evt_cmp_up), .evt_cmp_dn(evt_cmp_dn), .evt_zero(evt_zero),
    .evt_peak(evt_peak), .pwm_o(pwm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic to_end();
    for (int k = 0; k < 200 && !(cnt_o == 0 && dir_down_o); k++) tick();
  endtask

  task automatic run_period();
    mx = 0; npwm = 0; npk = 0;
    for (int k = 0; k < 200; k++) begin
      tick();
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
      npwm += int'(pwm_o);
      npk += int'(evt_peak);
      if (cnt_o == 0 && dir_down_o) break;
    end
  endtask

  task automatic late_cmp_write(input bit imm);
    do_reset();
    wr(0, 16'd10);
    wr(1, 16'd10);
    wr(2, imm ? 16'd3 : 16'd1);
    tick(); tick(); tick(); tick();
    wr(1, 16'd0);
    chk(pwm_o == 1'b1, imm ? "R8 shadow not yet updated" : "R6 shadow not yet updated",
        int'(pwm_o), 1);
    tick();
    if (imm) chk(pwm_o == 1'b0, "R8 immediate compare load", int'(pwm_o), 0);
    else     chk(pwm_o == 1'b1, "R6 mid-period compare held", int'(pwm_o), 1);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(cnt_o == 0 && !dir_down_o, "R1 count/dir after reset", int'(cnt_o), 0);
    chk({evt_cmp_up, evt_cmp_dn, evt_zero, evt_peak, pwm_o} == 5'b0,
        "R1 outputs idle after reset",
        int'({evt_cmp_up, evt_cmp_dn, evt_zero, evt_peak, pwm_o}), 0);

    // Table walk: R2 R3 R4 R5 R11
    for (int v = 0; v < NVEC; v++) begin
      int p, c, nup, ndn, npeak, nhi, nzero;
      bit traj_ok;
      p = int'(VEC[v][47:32]); c = int'(VEC[v][31:16]);
      nup = 0; ndn = 0; npeak = 0; nhi = 0; nzero = 0; traj_ok = 1;
      do_reset();
      wr(0, W'(p));
      wr(1, W'(c));
      wr(2, 16'd1);
      tick();
      for (int i = 0; i <= 2*p; i++) begin
        int ec;
        ec = (i <= p) ? i : 2*p - i;
        if (int'(cnt_o) != ec || dir_down_o != (i > p)) traj_ok = 0;
        nup += int'(evt_cmp_up); ndn += int'(evt_cmp_dn);
        npeak += int'(evt_peak); nhi += int'(pwm_o); nzero += int'(evt_zero);
        if (i < 2*p) tick();
      end
      chk(traj_ok, "R2 count trajectory", int'(cnt_o), 0);
      chk(nup == int'(VEC[v][15:12]), "R3 up-compare count", nup, int'(VEC[v][15:12]));
      chk(ndn == int'(VEC[v][11:8]), "R4 down-compare count", ndn, int'(VEC[v][11:8]));
      chk(npeak == int'(VEC[v][7:4]) && nzero == 2, "R5 peak/zero count",
          npeak * 10 + nzero, int'(VEC[v][7:4]) * 10 + 2);
      chk(nhi == int'(VEC[v][3:0]), "R11 pwm high cycles", nhi, int'(VEC[v][3:0]));
    end

    // R6: mid-period writes do not affect the running period
    do_reset();
    wr(0, 16'd4); wr(1, 16'd2); wr(2, 16'd1);
    tick(); tick(); tick();
    wr(1, 16'd3);
    wr(0, 16'd6);
    chk(cnt_o == 4 && evt_peak, "R6 old period peak kept", int'(cnt_o), 4);
    tick();
    chk(cnt_o == 3 && dir_down_o, "R6 turn at old period", int'(cnt_o), 3);
    to_end();
    run_period();
    chk(mx == 6 && npk == 1, "R6 new period next", mx, 6);
    chk(npwm == 5, "R6 new compare next", npwm, 5);
    // R7: compare-only write
    tick(); tick();
    wr(1, 16'd5);
    to_end();
    run_period();
    chk(mx == 6, "R7 period kept after compare write", mx, 6);
    chk(npwm == 9, "R7 compare updated alone", npwm, 9);

    // R6 versus R8: late compare write
    late_cmp_write(1'b0);
    late_cmp_write(1'b1);

    // R9: disable holds the count
    begin
      logic [W-1:0] held;
      bit quiet;
      wr(2, 16'd2);
      held = cnt_o; quiet = 1;
      for (int k = 0; k < 4; k++) begin
        tick();
        if (cnt_o != held || evt_cmp_up || evt_cmp_dn || evt_zero || evt_peak) quiet = 0;
      end
      chk(quiet && cnt_o == held, "R9 hold and no events when disabled", int'(cnt_o), int'(held));
    end

    // R10: zero period
    do_reset();
    wr(2, 16'd1);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(cnt_o == 0 && !dir_down_o && evt_zero, "R10 flat zero period",
          int'({cnt_o, evt_zero}), 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule